// File: doc/BRIEF.md
# Pattern Generator / Signature Compressor Test Cell

This block sits between a logic block under test and the rest of the board. It holds one 16-bit linear feedback shift register that a host controls over a JTAG test access port. One instruction makes the register a pseudo-random pattern generator, and its state drives the stimulus bus into the logic. Another instruction makes it a parallel signature compressor. In that mode it folds the logic's 16-bit response bus into its state on every step.

The host first scans in a seed and a run length. It then selects generate or compress and holds the TAP in Run-Test/Idle. The register advances once per test clock until the programmed number of steps has been taken, and then it freezes. The host then selects the signature-read instruction and shifts out the final state together with a completion flag. It compares that value with the known-good signature for the pattern sequence. Several cells can be handled in turn by one controller, because each cell carries the standard TAP, BYPASS and IDCODE.

Top module: `prpg_psa_cell`

## Requirements
- R1: After TRST the instruction is IDCODE (4'h1). A data scan then returns the 32-bit identification value, bit 0 first. An instruction scan captures 4'b0001. The pattern output reads 16'h0001.
- R2: Holding TMS high for five test clocks from any state reaches Test-Logic-Reset, and this restores the IDCODE instruction.
- R3: BYPASS (4'hF) and every undefined opcode select a 1-bit data path that captures 0. That path delays TDI by one clock and leaves the register unchanged.
- R4: SEED (4'h2) selects a 16-bit data path. Update-DR loads the scanned value into the register, and a scanned value of zero loads 16'h0001. The load also clears the step count.
- R5: GEN (4'h4) advances the register once per test clock spent in Run-Test/Idle. The register shifts left, and bit 0 takes s[15]^s[13]^s[12]^s[10]. The pattern output always shows the register.
- R6: COUNT (4'h3) selects a 16-bit data path whose Update-DR sets the run length and clears the step count. Stepping stops after exactly that many steps, and a length of 0 allows no step.
- R7: COMP (4'h5) steps in the same way as R5. The difference is that the response input is XORed into the shifted value.
- R8: SIGREAD (4'h6) selects a 17-bit path. Capture-DR loads {done, register}, register bit 0 is shifted out first and done is shifted out last. Done is 1 exactly when the step count equals the run length.
- R9: An asynchronous TRST in the middle of a run returns the register to 16'h0001, sets the run length to 0 (done), and returns the instruction to IDCODE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; also steps the shift register |
| trst | input | 1 | Asynchronous active-high test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, changes on falling tck |
| resp_i | input | 16 | Parallel response from the logic under test |
| pat_o | output | 16 | Pattern to the logic under test (register state) |

## Verification
Generate and compress runs are swept over a grid of seeds and run lengths. The seeds are one, zero, all-ones, top-bit-only and a mixed value. The run lengths are 0, 1, 17 and 100. The zero seed separates the seed substitution from a plain load. Length 0 and length 1 separate an off-by-one stop from a correct one. The long runs separate a wrong feedback tap set, because such a fault only shows up after many shifts.

In compress mode the response bus is a nonlinear function of the current state. This makes a missing or misplaced XOR change the signature. Idle clocks beyond the limit confirm the freeze, and reading the signature before a run confirms that done is clear. A bit pattern scanned through BYPASS and through an undefined opcode exposes a wrong path length.

// File: rtl/cell_pkg.sv
package cell_pkg;
  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE, TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PA_DR, TS_EX2_DR,
    TS_UP_DR, TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PA_IR, TS_EX2_IR, TS_UP_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_IDCODE = 4'h1;
  localparam logic [IR_W-1:0] OP_SEED   = 4'h2;
  localparam logic [IR_W-1:0] OP_COUNT  = 4'h3;
  localparam logic [IR_W-1:0] OP_GEN    = 4'h4;
  localparam logic [IR_W-1:0] OP_COMP   = 4'h5;
  localparam logic [IR_W-1:0] OP_SIG    = 4'h6;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'hF;
endpackage

// File: rtl/tc_tap_fsm.sv
module tc_tap_fsm
  import cell_pkg::*;
(
  input  logic       tck,
  input  logic       trst,
  input  logic       tms,
  output tap_state_e state_o
);
  tap_state_e st_q, st_d;

  always_comb begin
    unique case (st_q)
      TS_RESET:  st_d = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   st_d = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: st_d = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: st_d = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  st_d = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: st_d = tms ? TS_UP_DR  : TS_PA_DR;
      TS_PA_DR:  st_d = tms ? TS_EX2_DR : TS_PA_DR;
      TS_EX2_DR: st_d = tms ? TS_UP_DR  : TS_SH_DR;
      TS_UP_DR:  st_d = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: st_d = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: st_d = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  st_d = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: st_d = tms ? TS_UP_IR  : TS_PA_IR;
      TS_PA_IR:  st_d = tms ? TS_EX2_IR : TS_PA_IR;
      TS_EX2_IR: st_d = tms ? TS_UP_IR  : TS_SH_IR;
      TS_UP_IR:  st_d = tms ? TS_SEL_DR : TS_IDLE;
      default:   st_d = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or posedge trst) begin
    if (trst) st_q <= TS_RESET;
    else      st_q <= st_d;
  end

  assign state_o = st_q;

  AST_RESET_HOLD: assert property (@(posedge tck) disable iff (trst)
    (st_q == TS_RESET && tms) |=> (st_q == TS_RESET)); // R2
  AST_IDLE_STAY: assert property (@(posedge tck) disable iff (trst)
    (st_q == TS_IDLE && !tms) |=> (st_q == TS_IDLE)); // R5
endmodule

// File: rtl/tc_lfsr_engine.sv
module tc_lfsr_engine #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seed_we,
  input  logic [W-1:0] seed,
  input  logic         lim_we,
  input  logic [W-1:0] lim,
  input  logic         run,
  input  logic         psa_mode,
  input  logic [W-1:0] resp,
  output logic [W-1:0] state_o,
  output logic [W-1:0] limit_o,
  output logic         done_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] sr_q, cnt_q, lim_q, shifted, nxt;

  assign shifted = {sr_q[W-2:0], ^(sr_q & TAPS)};
  assign nxt     = psa_mode ? (shifted ^ resp) : shifted;
  assign done_o  = (cnt_q == lim_q);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sr_q  <= ONE;
      cnt_q <= '0;
      lim_q <= '0;
    end else if (seed_we) begin
      sr_q  <= (seed == '0) ? ONE : seed;
      cnt_q <= '0;
    end else if (lim_we) begin
      lim_q <= lim;
      cnt_q <= '0;
    end else if (run && !done_o) begin
      sr_q  <= nxt;
      cnt_q <= cnt_q + ONE;
    end
  end

  assign state_o = sr_q;
  assign limit_o = lim_q;

  AST_ZERO_SEED: assert property (@(posedge clk) disable iff (rst)
    (seed_we && seed == '0) |=> (sr_q == ONE)); // R4
  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (run && !psa_mode && !seed_we && !lim_we) |=> (sr_q != '0)); // R5
  AST_HOLD_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    (done_o && !seed_we && !lim_we) |=> $stable(sr_q)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (cnt_q <= lim_q)); // R6
endmodule

// File: rtl/prpg_psa_cell.sv
module prpg_psa_cell
  import cell_pkg::*;
#(
  parameter int           W      = 16,
  parameter logic [W-1:0] TAPS   = 16'hB400,
  parameter logic [31:0]  IDCODE = 32'h4C5A_1E01
) (
  input  logic         tck,
  input  logic         trst,
  input  logic         tms,
  input  logic         tdi,
  output logic         tdo,
  input  logic [W-1:0] resp_i,
  output logic [W-1:0] pat_o
);
  localparam int DR_W  = 32;
  localparam int LEN_W = $clog2(DR_W + 1);
  localparam int POS_W = $clog2(DR_W);

  tap_state_e      st;
  logic [IR_W-1:0] ir_q, ir_sh;
  logic [DR_W-1:0] dr_q, dr_cap, dr_nxt;
  logic [LEN_W-1:0] dr_len;
  logic [POS_W-1:0] ins_pos;
  logic [W-1:0]    lfsr, limit;
  logic            done, seed_we, lim_we, run, psa_mode;

  tc_tap_fsm u_tap (.tck(tck), .trst(trst), .tms(tms), .state_o(st));

  // Data path selection per instruction
  always_comb begin
    unique case (ir_q)
      OP_IDCODE: begin dr_len = LEN_W'(32);    dr_cap = IDCODE; end
      OP_SEED:   begin dr_len = LEN_W'(W);     dr_cap = DR_W'(lfsr); end
      OP_COUNT:  begin dr_len = LEN_W'(W);     dr_cap = DR_W'(limit); end
      OP_SIG:    begin dr_len = LEN_W'(W + 1); dr_cap = DR_W'({done, lfsr}); end
      default:   begin dr_len = LEN_W'(1);     dr_cap = '0; end
    endcase
  end

  assign ins_pos = POS_W'(dr_len - LEN_W'(1));

  always_comb begin
    dr_nxt          = {1'b0, dr_q[DR_W-1:1]};
    dr_nxt[ins_pos] = tdi;
  end

  always_ff @(posedge tck or posedge trst) begin
    if (trst) begin
      ir_q  <= OP_IDCODE;
      ir_sh <= '0;
    end else begin
      unique case (st)
        TS_RESET:  ir_q  <= OP_IDCODE;
        TS_CAP_IR: ir_sh <= IR_W'(1);
        TS_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        TS_UP_IR:  ir_q  <= ir_sh;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge tck or posedge trst) begin
    if (trst)                dr_q <= '0;
    else if (st == TS_CAP_DR) dr_q <= dr_cap;
    else if (st == TS_SH_DR)  dr_q <= dr_nxt;
  end

  always_ff @(negedge tck or posedge trst) begin
    if (trst)                tdo <= 1'b0;
    else if (st == TS_SH_IR) tdo <= ir_sh[0];
    else if (st == TS_SH_DR) tdo <= dr_q[0];
    else                     tdo <= 1'b0;
  end

  assign seed_we  = (st == TS_UP_DR) && (ir_q == OP_SEED);
  assign lim_we   = (st == TS_UP_DR) && (ir_q == OP_COUNT);
  assign psa_mode = (ir_q == OP_COMP);
  assign run      = (st == TS_IDLE) && ((ir_q == OP_GEN) || psa_mode);

  tc_lfsr_engine #(.W(W), .TAPS(TAPS)) u_eng (
    .clk(tck), .rst(trst), .seed_we(seed_we), .seed(dr_q[W-1:0]),
    .lim_we(lim_we), .lim(dr_q[W-1:0]), .run(run), .psa_mode(psa_mode),
    .resp(resp_i), .state_o(lfsr), .limit_o(limit), .done_o(done)
  );

  assign pat_o = lfsr;

  AST_IR_DEFAULT: assert property (@(posedge tck) disable iff (trst)
    (st == TS_RESET) |=> (ir_q == OP_IDCODE)); // R1
  AST_NO_STEP_OUTSIDE: assert property (@(posedge tck) disable iff (trst)
    (st != TS_IDLE && !seed_we) |=> $stable(lfsr)); // R3
endmodule

// File: tb/prpg_psa_cell_tb.sv
module prpg_psa_cell_tb_top;
  localparam int PER  = 10;
  localparam int HALF = PER / 2;
  localparam logic [31:0] IDC = 32'h4C5A_1E01;

  logic tck = 1'b0, trst = 1'b1, tms = 1'b1, tdi = 1'b0, tdo;
  logic [15:0] resp, pat;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #HALF tck = ~tck;

  function automatic logic [15:0] f_shift(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
  function automatic logic [15:0] f_resp(input logic [15:0] s);
    logic [15:0] m;
    m = 16'(s * 16'h6D2B);
    return m ^ 16'h5A3C;
  endfunction

  assign resp = f_resp(pat);

  prpg_psa_cell dut_i (.tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo),
                       .resp_i(resp), .pat_o(pat));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic d, output logic o);
    @(negedge tck); tms = t; tdi = d;
    #(HALF - 1); o = tdo;
    @(posedge tck); #1;
  endtask

  task automatic idle(input int n);
    logic b;
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, b);
  endtask

  task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
    logic b;
    cyc(1, 0, b); cyc(1, 0, b); cyc(0, 0, b); cyc(0, 0, b);
    for (int i = 0; i < 4; i++) begin cyc(i == 3, code[i], b); cap[i] = b; end
    cyc(1, 0, b); cyc(0, 0, b);
  endtask

  task automatic scan_dr(input int len, input logic [31:0] din, output logic [31:0] dout);
    logic b;
    dout = '0;
    cyc(1, 0, b); cyc(0, 0, b); cyc(0, 0, b);
    for (int i = 0; i < len; i++) begin cyc(i == len - 1, din[i], b); dout[i] = b; end
    cyc(1, 0, b); cyc(0, 0, b);
  endtask

  task automatic run_case(input logic [15:0] seed, input int n, input bit comp);
    logic [3:0]  c;
    logic [31:0] o;
    logic [15:0] s, e;
    s = (seed == 16'h0) ? 16'h0001 : seed;
    e = s;
    for (int k = 0; k < n; k++) e = comp ? (f_shift(e) ^ f_resp(e)) : f_shift(e);
    scan_ir(4'h2, c); scan_dr(16, {16'h0, seed}, o);
    chk("R4 seed load / zero substitution", {16'h0, pat}, {16'h0, s});
    scan_ir(4'h3, c); scan_dr(16, n, o);
    scan_ir(4'h6, c); scan_dr(17, 0, o);
    chk("R8 signature before run", o, {15'h0, (n == 0), s});
    scan_ir(comp ? 4'h5 : 4'h4, c);
    idle(n + 4);
    chk(comp ? "R7 compress result" : "R5 generate result", {16'h0, pat}, {16'h0, e});
    idle(5);
    chk("R6 frozen after limit", {16'h0, pat}, {16'h0, e});
    scan_ir(4'h6, c); scan_dr(17, 0, o);
    chk("R8 signature readout", o, {15'h0, 1'b1, e});
  endtask

  initial begin
    #(PER * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0]  c;
    logic [31:0] o;
    logic [15:0] seeds [5];
    int          lens  [4];
    logic [15:0] e;
    seeds = '{16'h0001, 16'h0000, 16'hFFFF, 16'h8000, 16'hACE1};
    lens  = '{0, 1, 17, 100};

    repeat (3) @(posedge tck);
    @(negedge tck); trst = 1'b0;
    #1;
    chk("R1 pattern after reset", {16'h0, pat}, 32'h1);
    idle(1);
    scan_dr(32, 0, o);
    chk("R1 IDCODE after reset", o, IDC);
    scan_ir(4'hF, c);
    chk("R1 IR capture pattern", {28'h0, c}, 32'h1);

    // R3 bypass and undefined opcode
    scan_dr(8, 32'hB2, o);
    chk("R3 bypass delay", o, 32'h164 & 32'hFF);
    chk("R3 bypass leaves register", {16'h0, pat}, 32'h1);
    scan_ir(4'h9, c);
    scan_dr(8, 32'h5D, o);
    chk("R3 undefined opcode bypass", o, 32'hBA);

    // R2 five TMS-high clocks
    scan_ir(4'hF, c);
    for (int i = 0; i < 5; i++) cyc(1, 0, c[0]);
    idle(1);
    scan_dr(32, 0, o);
    chk("R2 TMS reset restores IDCODE", o, IDC);

    for (int m = 0; m < 2; m++)
      for (int si = 0; si < 5; si++)
        for (int li = 0; li < 4; li++)
          run_case(seeds[si], lens[li], m == 1);

    // R5 exact step rate, then R9 asynchronous reset mid-run
    scan_ir(4'h2, c); scan_dr(16, 32'hACE1, o);
    scan_ir(4'h3, c); scan_dr(16, 1000, o);
    scan_ir(4'h4, c);
    idle(20);
    e = 16'hACE1;
    for (int k = 0; k < 20; k++) e = f_shift(e);
    chk("R5 one step per idle clock", {16'h0, pat}, {16'h0, e});
    @(negedge tck); #2 trst = 1'b1;
    #1;
    chk("R9 async reset clears register", {16'h0, pat}, 32'h1);
    @(posedge tck); @(negedge tck); trst = 1'b0; tms = 1'b1;
    idle(1);
    scan_dr(32, 0, o);
    chk("R9 IDCODE after mid-run reset", o, IDC);
    scan_ir(4'h6, c); scan_dr(17, 0, o);
    chk("R9 done and seed after reset", o, 32'h10001);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule